// File: doc/BRIEF.md
# Single-to-Half Precision Float Converter

This block turns an IEEE 754 single-precision word into a half-precision word. Each input word comes with a valid flag. The converted word leaves two clock cycles later with its own valid flag, so the block accepts one word per cycle and has no backpressure. Only round-to-nearest-even is supported, and the block raises no exception flags.

The block covers every class of input:

- Finite values with an exponent window that maps to half-precision normals are re-biased and rounded.
- Smaller values become shifted half-precision denormals. These are also rounded, and the rounding carry can move a result up into the next exponent.
- Values that are too large saturate to infinity.
- Zeros keep their sign, and input denormals flush to a signed zero.
- Infinities pass through.
- NaNs come out as quiet NaNs that keep the upper payload bits.

Top module: `fp32_to_fp16`

## Requirements
- R1: Field layout and normal mapping. The input has sign at bit 31, a biased exponent at bits 30:23 (bias 127) and a fraction at bits 22:0. The output has sign at bit 15, exponent at bits 14:10 (bias 15) and fraction at bits 9:0. An input exponent E from 113 to 142 gives output exponent E-112, and the output fraction is the top ten input fraction bits after rounding.
- R2: Rounding uses the first dropped bit as guard and the OR of all lower dropped bits as sticky. The result rounds up when guard is set and either sticky or the kept least significant bit is set. An exact tie therefore rounds to the even neighbour.
- R3: An input exponent from 143 to 254 gives infinity: exponent 31 and fraction 0. A rounding carry out of exponent 30 with an all-ones fraction also gives infinity.
- R4: An input exponent from 102 to 112 gives a denormal (output exponent 0). Its fraction is the significand (implicit one prepended) shifted right by 113-E positions beyond the normal alignment, then rounded. Exponent 112 gives a fraction of the form 0.1xxxxxxxxx. Inputs with exponent 101 or less, from 1 upward, give zero.
- R5: A rounding carry out of the largest denormal fraction produces the smallest normal, exponent 1 with fraction 0.
- R6: An input with exponent 0 gives a signed zero, whether the fraction is zero or not.
- R7: An input with exponent 255 and fraction 0 gives an infinity of the same sign.
- R8: An input with exponent 255 and a nonzero fraction gives a NaN with exponent 31. Output fraction bit 9 is set, and output fraction bits 8:0 copy input fraction bits 21:13.
- R9: Output bit 15 always equals input bit 31, for every class of input.
- R10: The output valid flag rises exactly two clock edges after an accepted input, and the result is on out_data in the same cycle. Input data with in_valid low gives no valid output. A synchronous active-low reset clears both pipeline valid flags and the output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input word is present this cycle |
| in_data | input | 32 | Single-precision input word |
| out_valid | output | 1 | Output word is present this cycle |
| out_data | output | 16 | Half-precision result |

## Verification
The assertions assume that in_valid and in_data hold defined values at every sampled clock edge after reset is released. They also assume that reset lasts long enough for both pipeline stages to clear, so the two-cycle look-back checks never straddle a reset boundary. The stimulus keeps to this by driving both inputs only on falling edges and holding reset for several cycles. It also keeps in_valid at a known level through every bubble and through the mid-stream reset test. All input bit patterns are legal, so the stimulus does not restrict data values. It only picks patterns that land on each exponent boundary and rounding corner.

// File: rtl/fp16c_pkg.sv
// Shared format constants and the stage-one record for the converter.
// Assumes IEEE 754 single and half precision field layouts.
package fp16c_pkg;

    localparam int SP_W         = 32;
    localparam int SP_EXP_W     = 8;
    localparam int SP_FRAC_W    = 23;
    localparam int SP_BIAS      = 127;
    localparam int HP_W         = 16;
    localparam int HP_EXP_W     = 5;
    localparam int HP_FRAC_W    = 10;
    localparam int HP_BIAS      = 15;

    localparam int BIAS_GAP     = SP_BIAS - HP_BIAS;          // 112
    localparam int FRAC_DROP    = SP_FRAC_W - HP_FRAC_W;      // 13
    localparam int HP_EXP_MAX   = (1 << HP_EXP_W) - 1;        // 31
    localparam int NORM_TOP     = BIAS_GAP + HP_EXP_MAX - 1;  // 142
    localparam int SUB_SHIFT_MAX = HP_FRAC_W + 2;             // 12
    localparam int SUB_FLOOR    = BIAS_GAP + 1 - SUB_SHIFT_MAX; // 101
    localparam int MANT_W       = SP_FRAC_W + 1;
    localparam int SH_W         = $clog2(MANT_W + 2);

    // Aligned magnitude before rounding, with its rounding bits.
    typedef struct packed {
        logic                sign;
        logic [HP_W-2:0]     body;
        logic                guard;
        logic                sticky;
    } hp_pre_t;

endpackage

// File: rtl/fp16c_unpack.sv
// Classifies a single-precision word and aligns it into half-precision
// exponent/fraction form with guard and sticky bits. Purely combinational.
// Assumes specials never need rounding, so guard and sticky stay zero for them.
module fp16c_unpack
    import fp16c_pkg::*;
(
    input  logic [SP_W-1:0] word_i,
    output hp_pre_t         pre_o
);

    localparam logic [SP_EXP_W-1:0] E_ALL1  = '1;
    localparam logic [SP_EXP_W-1:0] E_NTOP  = SP_EXP_W'(NORM_TOP);
    localparam logic [SP_EXP_W-1:0] E_GAP   = SP_EXP_W'(BIAS_GAP);
    localparam logic [SP_EXP_W-1:0] E_FLOOR = SP_EXP_W'(SUB_FLOOR);
    localparam logic [HP_EXP_W-1:0] H_ALL1  = '1;

    logic [SP_EXP_W-1:0]  exp_f;
    logic [SP_FRAC_W-1:0] frac_f;
    logic [MANT_W:0]      mant_x;
    logic [SP_EXP_W-1:0]  dsh;
    logic [SH_W-1:0]      sh;
    logic [MANT_W:0]      low_bit;

    assign exp_f  = word_i[SP_W-2 -: SP_EXP_W];
    assign frac_f = word_i[SP_FRAC_W-1:0];
    assign mant_x = {1'b0, 1'b1, frac_f};

    // Denormal right shift: one extra position per exponent step below the window.
    always_comb begin
        dsh = (exp_f <= E_FLOOR) ? SP_EXP_W'(SUB_SHIFT_MAX) : (E_GAP + SP_EXP_W'(1) - exp_f);
        sh  = SH_W'(FRAC_DROP) + SH_W'(dsh);
        low_bit = (MANT_W+1)'(1) << (sh - SH_W'(1));
    end

    // Class decode and alignment of the kept field.
    always_comb begin
        pre_o.sign   = word_i[SP_W-1];
        pre_o.body   = '0;
        pre_o.guard  = 1'b0;
        pre_o.sticky = 1'b0;
        if (exp_f == E_ALL1) begin
            if (frac_f != '0)
                pre_o.body = {H_ALL1, 1'b1, frac_f[SP_FRAC_W-2 -: HP_FRAC_W-1]};
            else
                pre_o.body = {H_ALL1, {HP_FRAC_W{1'b0}}};
        end else if (exp_f == '0) begin
            pre_o.body = '0;
        end else if (exp_f > E_NTOP) begin
            pre_o.body = {H_ALL1, {HP_FRAC_W{1'b0}}};
        end else if (exp_f > E_GAP) begin
            pre_o.body   = {HP_EXP_W'(exp_f - E_GAP), frac_f[SP_FRAC_W-1 -: HP_FRAC_W]};
            pre_o.guard  = frac_f[FRAC_DROP-1];
            pre_o.sticky = |frac_f[FRAC_DROP-2:0];
        end else begin
            pre_o.body   = {{HP_EXP_W{1'b0}}, HP_FRAC_W'(mant_x >> sh)};
            pre_o.guard  = mant_x[sh - SH_W'(1)];
            pre_o.sticky = |(mant_x & (low_bit - (MANT_W+1)'(1)));
        end
    end

endmodule

// File: rtl/fp16c_round.sv
// Round-to-nearest-even increment of an aligned half-precision magnitude.
// A carry out of the fraction moves naturally into the exponent field.
// Assumes the body is at most 0x7BFF whenever guard is set.
module fp16c_round
    import fp16c_pkg::*;
(
    input  hp_pre_t         pre_i,
    output logic [HP_W-1:0] half_o
);

    logic bump;

    // Round up on guard when the discarded tail is above half or the kept lsb is odd.
    always_comb begin
        bump   = pre_i.guard & (pre_i.sticky | pre_i.body[0]);
        half_o = {pre_i.sign, pre_i.body + (HP_W-1)'(bump)};
    end

endmodule

// File: rtl/fp32_to_fp16.sv
// Two-stage single-to-half converter. Stage one registers the classified
// and aligned value, stage two registers the rounded result. Valid rides
// alongside the data; there is no stall. Synchronous active-low reset.
module fp32_to_fp16
    import fp16c_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [SP_W-1:0] in_data,
    output logic            out_valid,
    output logic [HP_W-1:0] out_data
);

    hp_pre_t         pre_d;
    hp_pre_t         pre_q;
    logic            s1_valid;
    logic [HP_W-1:0] half_d;

    fp16c_unpack u_unpack (
        .word_i (in_data),
        .pre_o  (pre_d)
    );

    // Stage one: hold the aligned value and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            pre_q    <= '0;
        end else begin
            s1_valid <= in_valid;
            pre_q    <= pre_d;
        end
    end

    fp16c_round u_round (
        .pre_i  (pre_q),
        .half_o (half_d)
    );

    // Stage two: hold the rounded result and its valid flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= s1_valid;
            out_data  <= half_d;
        end
    end

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (out_valid == $past(in_valid, 2))); // R10

    AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(in_valid, 2))
        |-> (out_data[HP_W-1] == $past(in_data[SP_W-1], 2))); // R9

    AST_NAN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && (&out_data[HP_W-2 -: HP_EXP_W]) && (out_data[HP_FRAC_W-1:0] != '0))
        |-> out_data[HP_FRAC_W-1]); // R8

    AST_ZERO_EXP_IN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(in_valid, 2)
         && ($past(in_data[SP_W-2 -: SP_EXP_W], 2) == '0))
        |-> (out_data[HP_W-2:0] == '0)); // R6

    AST_BIG_TO_INF: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(in_valid, 2)
         && ($past(in_data[SP_W-2 -: SP_EXP_W], 2) > SP_EXP_W'(NORM_TOP))
         && ($past(in_data[SP_W-2 -: SP_EXP_W], 2) != '1))
        |-> (out_data[HP_W-2:0] == 15'h7C00)); // R3

    AST_SPECIAL_NO_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_valid && (&pre_q.body[HP_W-2 -: HP_EXP_W])) |-> !pre_q.guard); // R2

endmodule

// File: tb/sim_fp32_to_fp16.sv
`timescale 1ns/1ps
module sim_fp32_to_fp16;

    localparam int NV = 26;
    // {input word, expected half, requirement number}
    localparam logic [55:0] VEC [0:NV-1] = '{
        {32'h3F800000, 16'h3C00, 8'd1},  // R1 one
        {32'hC0000000, 16'hC000, 8'd9},  // R9 minus two
        {32'h477FE000, 16'h7BFF, 8'd1},  // R1 largest half
        {32'h477FF000, 16'h7C00, 8'd3},  // R3 carry out of exponent 30
        {32'h47800000, 16'h7C00, 8'd3},  // R3 exponent 143
        {32'h7F7FFFFF, 16'h7C00, 8'd3},  // R3 largest single
        {32'h3F801000, 16'h3C00, 8'd2},  // R2 tie, even stays
        {32'h3F803000, 16'h3C02, 8'd2},  // R2 tie, odd rounds up
        {32'h3F801001, 16'h3C01, 8'd2},  // R2 above tie
        {32'h38800000, 16'h0400, 8'd1},  // R1 smallest normal
        {32'h38000000, 16'h0200, 8'd4},  // R4 exponent 112
        {32'h33800000, 16'h0001, 8'd4},  // R4 smallest denormal
        {32'h33000000, 16'h0000, 8'd4},  // R4 half of smallest, tie to zero
        {32'h33000001, 16'h0001, 8'd4},  // R4 just above half
        {32'h32FFFFFF, 16'h0000, 8'd4},  // R4 exponent 101
        {32'h387FFFFF, 16'h0400, 8'd5},  // R5 denormal carry to normal
        {32'h00000000, 16'h0000, 8'd6},  // R6 plus zero
        {32'h80000000, 16'h8000, 8'd6},  // R6 minus zero
        {32'h80000001, 16'h8000, 8'd6},  // R6 input denormal
        {32'h7F800000, 16'h7C00, 8'd7},  // R7 plus infinity
        {32'hFF800000, 16'hFC00, 8'd7},  // R7 minus infinity
        {32'h7FC00000, 16'h7E00, 8'd8},  // R8 quiet NaN
        {32'hFF800001, 16'hFE00, 8'd8},  // R8 signalling NaN, negative
        {32'h7FA00000, 16'h7F00, 8'd8},  // R8 payload bit kept
        {32'hBFC00000, 16'hBE00, 8'd9},  // R9 minus one and a half
        {32'h37000000, 16'h0080, 8'd4}   // R4 exponent 110
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        out_valid;
    logic [15:0] out_data;
    int          n_chk = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    fp32_to_fp16 u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        #(20 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R10 reset valid", {31'b0, out_valid}, 32'd0);
        chk("R10 reset data", {16'b0, out_data}, 32'd0);
        rst_n = 1'b1;

        // Back-to-back stream through the table.
        for (int j = 0; j < NV + 2; j++) begin
            @(negedge clk);
            if (j >= 2) begin
                chk($sformatf("R%0d valid #%0d", VEC[j-2][7:0], j-2), {31'b0, out_valid}, 32'd1);
                chk($sformatf("R%0d data #%0d", VEC[j-2][7:0], j-2), {16'b0, out_data},
                    {16'b0, VEC[j-2][23:8]});
            end
            if (j < NV) begin
                in_valid = 1'b1;
                in_data  = VEC[j][55:24];
            end else begin
                in_valid = 1'b0;
            end
        end

        // Data present with valid low gives no output.
        in_data = 32'h3F800000;
        @(negedge clk); @(negedge clk);
        chk("R10 no valid in", {31'b0, out_valid}, 32'd0);

        // Gapped pattern: A, bubble, B.
        in_valid = 1'b1; in_data = 32'hC0000000;
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk); in_valid = 1'b1; in_data = 32'h7F800000;
        chk("R10 gap A valid", {31'b0, out_valid}, 32'd1);
        chk("R9 gap A data", {16'b0, out_data}, 32'h0000C000);
        @(negedge clk); in_valid = 1'b0;
        chk("R10 gap bubble", {31'b0, out_valid}, 32'd0);
        @(negedge clk);
        chk("R10 gap B valid", {31'b0, out_valid}, 32'd1);
        chk("R7 gap B data", {16'b0, out_data}, 32'h00007C00);

        // Reset while a word is in flight drops it.
        in_valid = 1'b1; in_data = 32'h3F800000;
        @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        chk("R10 flush valid", {31'b0, out_valid}, 32'd0);
        chk("R10 flush data", {16'b0, out_data}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk("R10 after flush", {31'b0, out_valid}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule